// File: doc/BRIEF.md
# Time-Slot Interchange Switch

The block moves eight-bit channels between a small set of time-division multiplexed streams. Each clock cycle is one timeslot. In that cycle, one byte from every input stream is presented in parallel, and one byte for every output stream is produced. A frame is `NCH` timeslots long, and the slot counter wraps at the frame boundary. Incoming bytes are stored in a two-bank data memory. Any input channel can reach any output channel, and every input channel can be in use at the same time, so the switch is non-blocking.

A connection memory has one entry for each output stream and timeslot. The entry chooses what that output channel carries:
- a switched byte, taken either exactly one frame late or with the shortest possible latency;
- a constant all-ones byte;
- a message byte held in the entry itself;
- nothing, with the output enable low.

A host reaches the connection memory and two registers through a single-cycle request bus. A bulk fill copies a seed value into every entry. While the fill runs, host accesses to the connection memory fail and all outputs are quiet. The fill also runs on its own after reset, with a seed of zero.

Top module: `tsi_switch`

## Requirements
- R1: `slot_o` counts 0, 1, …, NCH-1 and then wraps to 0, one step per clock, starting at 0 in the first cycle after reset. `tx_slot` equals the slot the outputs belong to, which is `slot_o` one cycle earlier.
- R2: Connection entry layout: [11:9] is the function code, [8] is the variable-delay flag, and [7:0] is the payload. When switching, the source slot is in payload[2:0] and the source stream in payload[4:3]. With codes 011, 100 or 101 and flag 0, the output byte for slot t of frame F equals the source stream's input byte at slot s of frame F-1.
- R3: With a switch code and flag 1, the source byte comes from the current frame when the source slot s is less than t. Otherwise, including s equal to t, it comes from the previous frame.
- R4: Code 001 drives 8'hFF with the enable high. Codes 000, 110 and 111 drive the enable low and the data 0.
- R5: Code 010 sends payload[7:0] with the enable high.
- R6: Host map. `h_addr[5]`=0 addresses connection entry `stream*NCH + slot`. 6'b100000 is the seed register and can be read and written. 6'b100001 is control: writing bit0=1 starts a fill, and reading gives the busy flag in bit0. `h_ack`, `h_rdata` and `h_err` arrive one cycle after `h_req`.
- R7: A fill writes the seed into every entry, one entry per cycle, for NSTR*NCH cycles. The busy flag reads 1 from the cycle after the start request until the fill ends, then reads 0.
- R8: A connection-memory access made while busy returns `h_err`=1 and read data 0, and a write made then is dropped.
- R9: Every output enable and data byte is 0 for each timeslot during which a fill is running.
- R10: Writing the seed register during a fill changes the register but not the value being copied.
- R11: During reset the outputs are 0 and the slot is 0. A fill with seed 0 is busy for the first NSTR*NCH cycles after reset, which leaves every entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timeslot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | NSTR*8 | Input bytes for the current slot, stream n in bits [8n+7:8n] |
| slot_o | output | log2(NCH) | Current input timeslot |
| tx_data | output | NSTR*8 | Output bytes, stream n in bits [8n+7:8n] |
| tx_oe | output | NSTR | Per-stream output enable |
| tx_slot | output | log2(NCH) | Timeslot that the outputs belong to |
| h_req | input | 1 | Host request |
| h_wr | input | 1 | Host write (1) or read (0) |
| h_addr | input | log2(NSTR*NCH)+1 | Host address |
| h_wdata | input | 12 | Host write data |
| h_rdata | output | 12 | Host read data |
| h_ack | output | 1 | Response valid |
| h_err | output | 1 | Access refused during a fill |

## Verification
Output bytes are registered, so the result for the timeslot started at one falling edge is sampled at the next falling edge. At that point the bench compares `tx_slot` against the slot it drove one cycle earlier. The bench builds each input byte from the cycle index, so it recomputes the expected source cycle from the frame, the slot and the delay rule, with no stored history. Host responses are sampled one edge after the request. The bench opens a fill window starting the cycle after the start request and lasting exactly NSTR*NCH cycles, and inside that window it expects quiet outputs. Output checks are suspended while the host is rewriting entries.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam logic [2:0] FN_HIGH = 3'b001;
  localparam logic [2:0] FN_MSG  = 3'b010;

  typedef enum logic [1:0] {ACT_Z, ACT_HIGH, ACT_MSG, ACT_SW} act_e;

  function automatic act_e fn_decode(input logic [2:0] fn);
    case (fn)
      FN_HIGH:                fn_decode = ACT_HIGH;
      FN_MSG:                 fn_decode = ACT_MSG;
      3'b011, 3'b100, 3'b101: fn_decode = ACT_SW;
      default:                fn_decode = ACT_Z;
    endcase
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
  parameter int NCH = 8,
  localparam int SLW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  output logic [SLW-1:0] slot,
  output logic           bank
);
  localparam logic [SLW-1:0] LAST = SLW'(NCH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      bank <= 1'b0;
    end else if (slot == LAST) begin
      slot <= '0;
      bank <= ~bank;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  a_r1_slot_wrap: assert property (@(posedge clk) disable iff (rst)
    slot == LAST |=> slot == '0);
  a_r1_slot_step: assert property (@(posedge clk) disable iff (rst)
    slot != LAST |=> slot == $past(slot) + 1'b1);
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (rst)
    slot != '0 |-> $stable(bank));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int NSTR = 4,
  parameter int NCH  = 8,
  parameter int BW   = 8,
  localparam int SLW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int STW = (NSTR > 1) ? $clog2(NSTR) : 1,
  localparam int RAW = 1 + STW + SLW
) (
  input  logic                clk,
  input  logic                wr_bank,
  input  logic [SLW-1:0]      wr_slot,
  input  logic [NSTR*BW-1:0]  wr_data,
  input  logic [NSTR*RAW-1:0] rd_addr,
  output logic [NSTR*BW-1:0]  rd_data
);
  localparam int DEP = 2 ** (SLW + 1);

  logic [BW-1:0] ram [NSTR][DEP];

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTR; s++)
      ram[s][{wr_bank, wr_slot}] <= wr_data[s*BW +: BW];
  end

  for (genvar l = 0; l < NSTR; l++) begin : g_rd
    logic           r_bank;
    logic [STW-1:0] r_str;
    logic [SLW-1:0] r_slot;
    assign r_bank = rd_addr[l*RAW + RAW - 1];
    assign r_str  = rd_addr[l*RAW + SLW +: STW];
    assign r_slot = rd_addr[l*RAW +: SLW];
    assign rd_data[l*BW +: BW] = ram[r_str][{r_bank, r_slot}];
  end
endmodule

// File: rtl/tsi_conn_ctl.sv
module tsi_conn_ctl #(
  parameter int NSTR = 4,
  parameter int NCH  = 8,
  parameter int BW   = 8,
  localparam int SLW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NENT = NSTR * NCH,
  localparam int CAW  = $clog2(NENT),
  localparam int AW   = CAW + 1,
  localparam int CMW  = BW + 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SLW-1:0]      cur_slot,
  output logic [NSTR*CMW-1:0] lane_ent,
  output logic                busy,
  input  logic                h_req,
  input  logic                h_wr,
  input  logic [AW-1:0]       h_addr,
  input  logic [CMW-1:0]      h_wdata,
  output logic [CMW-1:0]      h_rdata,
  output logic                h_ack,
  output logic                h_err
);
  logic [CMW-1:0] cm [NENT];
  logic [CAW-1:0] idx;
  logic [CMW-1:0] seed_reg, seed_lat;

  logic           cm_sel, idx_ok, cm_wr, start, seed_wr, last;
  logic [CAW-1:0] h_idx;

  assign cm_sel  = ~h_addr[AW-1];
  assign h_idx   = h_addr[CAW-1:0];
  assign idx_ok  = int'(h_idx) < NENT;
  assign cm_wr   = h_req & h_wr & cm_sel & ~busy & idx_ok;
  assign start   = h_req & h_wr & ~cm_sel & h_addr[0] & h_wdata[0] & ~busy;
  assign seed_wr = h_req & h_wr & ~cm_sel & ~h_addr[0];
  assign last    = idx == CAW'(NENT - 1);

  always_ff @(posedge clk) begin
    if (busy)       cm[idx]   <= seed_lat;
    else if (cm_wr) cm[h_idx] <= h_wdata;
  end

  for (genvar s = 0; s < NSTR; s++) begin : g_lane
    assign lane_ent[s*CMW +: CMW] = cm[CAW'(s*NCH) + CAW'(cur_slot)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      idx      <= '0;
      seed_lat <= '0;
      seed_reg <= '0;
      h_ack    <= 1'b0;
      h_err    <= 1'b0;
      h_rdata  <= '0;
    end else begin
      if (busy) begin
        idx <= idx + 1'b1;
        if (last) busy <= 1'b0;
      end else if (start) begin
        busy     <= 1'b1;
        idx      <= '0;
        seed_lat <= seed_reg;
      end
      if (seed_wr) seed_reg <= h_wdata;
      h_ack <= h_req;
      h_err <= h_req & cm_sel & busy;
      if (!h_req)                     h_rdata <= '0;
      else if (cm_sel)                h_rdata <= (busy || !idx_ok) ? '0 : cm[h_idx];
      else if (h_addr[0])             h_rdata <= CMW'(busy);
      else                            h_rdata <= seed_reg;
    end
  end

  a_r8_err_busy: assert property (@(posedge clk) disable iff (rst)
    h_req && cm_sel && busy |=> h_ack && h_err && h_rdata == '0);
  a_r8_no_err_idle: assert property (@(posedge clk) disable iff (rst)
    h_req && !busy |=> h_ack && !h_err);
  a_r7_full_sweep: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(idx) == CAW'(NENT - 1));
  a_r10_seed_hold: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(seed_lat));
endmodule

// File: rtl/tsi_out_lane.sv
module tsi_out_lane
  import tsi_pkg::*;
#(
  parameter int NSTR = 4,
  parameter int NCH  = 8,
  parameter int BW   = 8,
  localparam int SLW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int STW = (NSTR > 1) ? $clog2(NSTR) : 1,
  localparam int RAW = 1 + STW + SLW,
  localparam int CMW = BW + 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           busy,
  input  logic [SLW-1:0] cur_slot,
  input  logic           wbank,
  input  logic [CMW-1:0] ent,
  output logic [RAW-1:0] rd_addr,
  input  logic [BW-1:0]  rd_data,
  output logic [BW-1:0]  tx_d,
  output logic           tx_oe
);
  logic [2:0]     fn;
  logic           vdl, live;
  logic [SLW-1:0] sslot;
  logic [STW-1:0] sstr;
  act_e           act;

  assign fn      = ent[CMW-1 -: 3];
  assign vdl     = ent[BW];
  assign sslot   = ent[SLW-1:0];
  assign sstr    = ent[SLW +: STW];
  assign live    = vdl & (sslot < cur_slot);
  assign rd_addr = {live ? wbank : ~wbank, sstr, sslot};
  assign act     = fn_decode(fn);

  always_ff @(posedge clk) begin
    if (rst || busy) begin
      tx_oe <= 1'b0;
      tx_d  <= '0;
    end else begin
      case (act)
        ACT_HIGH: begin tx_oe <= 1'b1; tx_d <= '1;           end
        ACT_MSG:  begin tx_oe <= 1'b1; tx_d <= ent[BW-1:0];  end
        ACT_SW:   begin tx_oe <= 1'b1; tx_d <= rd_data;      end
        default:  begin tx_oe <= 1'b0; tx_d <= '0;           end
      endcase
    end
  end

  a_r9_quiet_fill: assert property (@(posedge clk) disable iff (rst)
    busy |=> !tx_oe && tx_d == '0);
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int NSTR = 4,
  parameter int NCH  = 8,
  parameter int BW   = 8,
  localparam int SLW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int STW  = (NSTR > 1) ? $clog2(NSTR) : 1,
  localparam int RAW  = 1 + STW + SLW,
  localparam int NENT = NSTR * NCH,
  localparam int AW   = $clog2(NENT) + 1,
  localparam int CMW  = BW + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSTR*BW-1:0] rx_data,
  output logic [SLW-1:0]     slot_o,
  output logic [NSTR*BW-1:0] tx_data,
  output logic [NSTR-1:0]    tx_oe,
  output logic [SLW-1:0]     tx_slot,
  input  logic               h_req,
  input  logic               h_wr,
  input  logic [AW-1:0]      h_addr,
  input  logic [CMW-1:0]     h_wdata,
  output logic [CMW-1:0]     h_rdata,
  output logic               h_ack,
  output logic               h_err
);
  logic [SLW-1:0]      cur_slot;
  logic                wbank, busy;
  logic [NSTR*CMW-1:0] lane_ent;
  logic [NSTR*RAW-1:0] rd_addr;
  logic [NSTR*BW-1:0]  rd_data;

  tsi_frame_timer #(.NCH(NCH)) u_tmr (
    .clk(clk), .rst(rst), .slot(cur_slot), .bank(wbank));

  tsi_conn_ctl #(.NSTR(NSTR), .NCH(NCH), .BW(BW)) u_cm (
    .clk(clk), .rst(rst), .cur_slot(cur_slot), .lane_ent(lane_ent), .busy(busy),
    .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_ack(h_ack), .h_err(h_err));

  tsi_data_mem #(.NSTR(NSTR), .NCH(NCH), .BW(BW)) u_dm (
    .clk(clk), .wr_bank(wbank), .wr_slot(cur_slot), .wr_data(rx_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  for (genvar s = 0; s < NSTR; s++) begin : g_out
    tsi_out_lane #(.NSTR(NSTR), .NCH(NCH), .BW(BW)) u_lane (
      .clk(clk), .rst(rst), .busy(busy), .cur_slot(cur_slot), .wbank(wbank),
      .ent(lane_ent[s*CMW +: CMW]), .rd_addr(rd_addr[s*RAW +: RAW]),
      .rd_data(rd_data[s*BW +: BW]), .tx_d(tx_data[s*BW +: BW]), .tx_oe(tx_oe[s]));
  end

  always_ff @(posedge clk) begin
    if (rst) tx_slot <= '0;
    else     tx_slot <= cur_slot;
  end

  assign slot_o = cur_slot;

  a_r1_tx_slot_lag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tx_slot == $past(cur_slot));
endmodule

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
  localparam int NSTR = 4, NCH = 8, BW = 8, SLW = 3, NENT = 32, CMW = 12, AW = 6;
  localparam logic [AW-1:0] A_SEED = 6'b100000, A_CTRL = 6'b100001;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst;
  logic [NSTR*BW-1:0] rx_data;
  logic [SLW-1:0]     slot_o, tx_slot;
  logic [NSTR*BW-1:0] tx_data;
  logic [NSTR-1:0]    tx_oe;
  logic               h_req, h_wr, h_ack, h_err;
  logic [AW-1:0]      h_addr;
  logic [CMW-1:0]     h_wdata, h_rdata;

  tsi_switch #(.NSTR(NSTR), .NCH(NCH), .BW(BW)) u0 (
    .clk(clk), .rst(rst), .rx_data(rx_data), .slot_o(slot_o), .tx_data(tx_data),
    .tx_oe(tx_oe), .tx_slot(tx_slot), .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ack(h_ack), .h_err(h_err));

  int errs = 0, checks = 0, cyc = 0;
  int bz_lo = 0, bz_hi = -1;
  bit chk_on = 1'b0;
  logic [CMW-1:0] mcm [NENT];

  function automatic logic [7:0] pat(int c, int s);
    return 8'(c * 7 + s * 53 + 11);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic drive_rx(int c);
    for (int s = 0; s < NSTR; s++) rx_data[s*BW +: BW] = pat(c, s);
  endtask

  task automatic check_out(int k);
    int t, f;
    bit bz;
    t  = k % NCH;
    f  = k / NCH;
    bz = (k >= bz_lo) && (k <= bz_hi);
    chk(tx_slot == SLW'(t), "R1 tx_slot", 32'(tx_slot), 32'(t));
    for (int s = 0; s < NSTR; s++) begin
      logic [CMW-1:0] e;
      logic           ev;
      logic [7:0]     ed;
      string          tag;
      int             src, ss, st;
      e = mcm[s*NCH + t];
      if (bz) begin
        ev = 1'b0; ed = 8'h00; tag = "R9 quiet during fill";
      end else begin
        case (e[11:9])
          3'b001: begin ev = 1'b1; ed = 8'hFF; tag = "R4 drive high"; end
          3'b010: begin ev = 1'b1; ed = e[7:0]; tag = "R5 message"; end
          3'b011, 3'b100, 3'b101: begin
            ss  = int'(e[4:3]);
            st  = int'(e[2:0]);
            src = (e[8] && st < t) ? f * NCH + st : (f - 1) * NCH + st;
            ev  = 1'b1;
            ed  = pat(src, ss);
            tag = e[8] ? "R3 variable delay" : "R2 constant delay";
          end
          default: begin ev = 1'b0; ed = 8'h00; tag = "R4 high impedance"; end
        endcase
      end
      chk(tx_oe[s] == ev && tx_data[s*BW +: BW] == ed, tag,
          {23'd0, tx_oe[s], tx_data[s*BW +: BW]}, {23'd0, ev, ed});
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (chk_on) begin
      check_out(cyc - 1);
      chk(slot_o == SLW'(cyc % NCH), "R1 slot_o", 32'(slot_o), 32'(cyc % NCH));
    end
    drive_rx(cyc);
    cyc++;
  endtask

  task automatic host(bit wr, logic [AW-1:0] a, logic [CMW-1:0] d,
                      output logic [CMW-1:0] rd, output logic er);
    h_req = 1'b1; h_wr = wr; h_addr = a; h_wdata = d;
    step();
    chk(h_ack == 1'b1, "R6 ack", 32'(h_ack), 32'd1);
    rd = h_rdata;
    er = h_err;
    h_req = 1'b0; h_wr = 1'b0;
  endtask

  task automatic put(int i, logic [CMW-1:0] v);
    logic [CMW-1:0] rd;
    logic er;
    host(1'b1, AW'(i), v, rd, er);
    chk(er == 1'b0, "R8 no error when idle", 32'(er), 32'd0);
    mcm[i] = v;
  endtask

  task automatic run_until(int c);
    chk_on = 1'b1;
    while (cyc < c) step();
    chk_on = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(200000 * 10);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    logic [CMW-1:0] rd;
    logic er;
    int c0;
    rst = 1'b1; h_req = 1'b0; h_wr = 1'b0; h_addr = '0; h_wdata = '0; rx_data = '0;
    for (int i = 0; i < NENT; i++) mcm[i] = '0;
    repeat (3) @(negedge clk);
    chk(tx_oe == '0 && tx_data == '0, "R11 reset outputs", 32'(tx_oe), 32'd0);
    chk(slot_o == '0, "R11 reset slot", 32'(slot_o), 32'd0);
    chk(h_ack == 1'b0, "R11 reset ack", 32'(h_ack), 32'd0);
    rst = 1'b0;
    drive_rx(0);
    cyc = 1;
    bz_lo = 0; bz_hi = NENT - 1;

    // R11: reset-time fill is busy and refuses memory access
    host(1'b0, A_CTRL, '0, rd, er);
    chk(rd[0] == 1'b1, "R11 busy after reset", 32'(rd), 32'd1);
    host(1'b0, AW'(5), '0, rd, er);
    chk(er == 1'b1 && rd == '0, "R8 error while busy", {19'd0, er, rd}, 32'h1000);
    run_until(44);
    host(1'b0, A_CTRL, '0, rd, er);
    chk(rd[0] == 1'b0, "R7 busy cleared", 32'(rd), 32'd0);
    for (int i = 0; i < NENT; i++) begin
      host(1'b0, AW'(i), '0, rd, er);
      chk(rd == '0 && er == 1'b0, "R11 entry zero", 32'(rd), 32'd0);
    end

    // R2: constant delay, switch code 011, permuted sources
    for (int s = 0; s < NSTR; s++)
      for (int t = 0; t < NCH; t++)
        put(s*NCH + t, {3'b011, 1'b0, 3'b000, 2'((s + t) % NSTR), 3'((t * 3 + s) % NCH)});
    for (int i = 0; i < NENT; i += 7) begin
      host(1'b0, AW'(i), '0, rd, er);
      chk(rd == mcm[i], "R6 entry readback", 32'(rd), 32'(mcm[i]));
    end
    run_until(cyc + 3 * NCH);

    // R3: variable delay, sources before, at and after the output slot
    for (int s = 0; s < NSTR; s++)
      for (int t = 0; t < NCH; t++)
        put(s*NCH + t, {(s % 2 == 1) ? 3'b100 : 3'b101, 1'b1, 3'b000,
                        2'((s + 3) % NSTR), 3'((NCH - 1 - t + s) % NCH)});
    run_until(cyc + 3 * NCH);

    // R4, R5: every function code with varying payloads
    for (int s = 0; s < NSTR; s++)
      for (int t = 0; t < NCH; t++)
        put(s*NCH + t, {3'((s * NCH + t) % 8), 1'(t % 2), 8'(s * 16 + t * 5 + 64)});
    run_until(cyc + 3 * NCH);

    // R7, R8, R9, R10: host-started fill
    host(1'b1, A_SEED, 12'h2A5, rd, er);
    c0 = cyc - 1;
    host(1'b1, A_CTRL, 12'h001, rd, er);
    bz_lo = c0 + 1; bz_hi = c0 + NENT;
    host(1'b1, A_SEED, 12'h4C3, rd, er);
    host(1'b1, AW'(3), 12'h655, rd, er);
    chk(er == 1'b1, "R8 write refused while busy", 32'(er), 32'd1);
    host(1'b0, A_CTRL, '0, rd, er);
    chk(rd[0] == 1'b1, "R7 busy during fill", 32'(rd), 32'd1);
    for (int i = 0; i < NENT; i++) mcm[i] = 12'h2A5;
    run_until(bz_hi + 2 * NCH + 2);
    host(1'b0, A_CTRL, '0, rd, er);
    chk(rd[0] == 1'b0, "R7 busy cleared after fill", 32'(rd), 32'd0);
    for (int i = 0; i < NENT; i++) begin
      host(1'b0, AW'(i), '0, rd, er);
      chk(rd == 12'h2A5, "R10 fill used latched seed", 32'(rd), 32'h2A5);
    end
    host(1'b0, A_SEED, '0, rd, er);
    chk(rd == 12'h4C3, "R6 seed register readback", 32'(rd), 32'h4C3);

    report();
    $finish;
  end
endmodule